// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent 16-bit count registers, each visible as a low byte and a high byte, and one shared configuration byte. Each unit counts either internal time or external events. As a timer it advances on a shared prescaled tick, which comes every 12 clocks or, with the fast select, every 4 clocks. As a counter it advances on falling transitions of its own external input. That input is sampled once per clock, so a falling transition means one sample of 1 and then a sample of 0. A gate pin can qualify either kind of counting.

Four counting layouts are available: a 13-bit count, a full 16-bit count, an 8-bit count that reloads from the high byte, and a split layout that makes unit 0 into two 8-bit counters. When a unit wraps, its sticky overflow flag is set and a one-clock overflow pulse is sent out. A serial port can use that pulse as its rate source. The register port is a plain byte interface. Its write strobe takes effect at the clock edge, reads are combinational, and there is no handshake or back-pressure. Run, gate, fast-select and flag-clear are plain level inputs.

Top module: `tmr_pair`

## Requirements
- R1: After reset all four count bytes, the configuration byte, both overflow flags and both overflow pulses read 0.
- R2: Register addresses are 0 for unit 0 low byte, 1 for unit 0 high byte, 2 for unit 1 low byte, 3 for unit 1 high byte and 4 for configuration. A value written to any of them reads back unchanged while the units are stopped.
- R3: Configuration nibble per unit (unit 0 in bits 3:0, unit 1 in bits 7:4): bit 3 is gate enable, bit 2 selects the external input (1) or the prescaled tick (0), bits 1:0 select the layout (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split). In tick mode a running unit advances once per 12 clocks with fast_sel low and once per 4 clocks with fast_sel high.
- R4: With its run bit low, a unit does not advance.
- R5: In external mode a unit advances once for each falling transition of its input between consecutive clock samples. Rising transitions and steady levels have no effect.
- R6: With gate enable set, counting also needs the gate pin high. With gate enable clear, the gate pin is ignored.
- R7: In 16-bit layout, FFFF advances to 0000. This sets the unit's overflow flag and raises its overflow pulse for exactly one clock.
- R8: In 13-bit layout, the high byte and low-byte bits 4:0 form the count. Low-byte bits 7:5 do not change, and overflow happens when all 13 count bits are 1.
- R9: In 8-bit reload layout, when the low byte advances past FF it loads the high byte and overflows. The high byte itself does not change.
- R10: In split layout, unit 0's low byte counts under unit 0's controls, and unit 0's high byte counts prescaled ticks while run[1] is high. The high byte's overflow drives flag 1 and pulse 1. A unit 1 set to the split layout holds its value.
- R11: An overflow flag stays set until its flag_clr bit is raised. If a set and a clear happen in the same cycle, the set wins.
- R12: A register write to a count byte in the same cycle as an increment of that byte stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| fast_sel | input | 1 | Prescale select, 1 = divide by 4 |
| run | input | 2 | Per-unit run enable |
| cnt_in | input | 2 | Per-unit external count input |
| gate_in | input | 2 | Per-unit gate pin |
| flag_clr | input | 2 | Per-unit overflow flag clear |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_pulse | output | 2 | One-clock overflow pulses (rate source) |

## Verification
The hardest case to reach from the ports is a register write that lands in the same cycle as an increment of the same byte, because the increment arrives two registers after the external input changes. The stimulus drops the count input at one falling clock edge and raises the write strobe at the next one. This places the detected transition in the same cycle as the write. The split-layout overflow on flag 1 is reached by preloading the high byte near FF and running only unit 1's run bit for an exact multiple of the prescale period. Random edge patterns and gate toggles from a fixed seed are scored against a bench count of 1-then-0 sample pairs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;

  typedef enum logic [1:0] {
    LAY_13    = 2'd0,
    LAY_16    = 2'd1,
    LAY_RLD   = 2'd2,
    LAY_SPLIT = 2'd3
  } tmr_lay_e;

  typedef struct packed {
    logic     gate_en;
    logic     ext_src;
    tmr_lay_e lay;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sel,
  output logic tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = fast_sel ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [N-1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= pin;
      prev_q <= cur_q;
    end
  end

  assign fall = prev_q & ~cur_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_lay_e lay,
  input  logic     inc,
  input  logic     inc_hi,
  input  logic     wr_lo,
  input  logic     wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo,
  output logic [7:0] hi,
  output logic     ovf,
  output logic     ovf_hi
);
  logic [7:0]  lo_n, hi_n;
  logic [12:0] v13, v13_n;
  logic [15:0] v16_n;

  assign v13   = {hi, lo[4:0]};
  assign v13_n = v13 + 13'd1;
  assign v16_n = {hi, lo} + 16'd1;

  always_comb begin
    lo_n   = lo;
    hi_n   = hi;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    unique case (lay)
      LAY_13: if (inc) begin
        lo_n = {lo[7:5], v13_n[4:0]};
        hi_n = v13_n[12:5];
        ovf  = &v13;
      end
      LAY_16: if (inc) begin
        {hi_n, lo_n} = v16_n;
        ovf = &{hi, lo};
      end
      LAY_RLD: if (inc) begin
        if (&lo) begin
          lo_n = hi;
          ovf  = 1'b1;
        end else begin
          lo_n = lo + 8'd1;
        end
      end
      LAY_SPLIT: if (SPLIT_OK) begin
        if (inc) begin
          lo_n = lo + 8'd1;
          ovf  = &lo;
        end
        if (inc_hi) begin
          hi_n   = hi + 8'd1;
          ovf_hi = &hi;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : lo_n;
      hi <= wr_hi ? wdata : hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       fast_sel,
  input  logic [1:0] run,
  input  logic [1:0] cnt_in,
  input  logic [1:0] gate_in,
  input  logic [1:0] flag_clr,
  output logic [1:0] ovf_flag,
  output logic [1:0] ovf_pulse
);
  localparam int NU = 2;

  logic [7:0] cfg_q;
  logic       tick;
  logic [NU-1:0] fall, inc, ovf, ovf_hi, set_v;
  logic [7:0] lo_v [NU];
  logic [7:0] hi_v [NU];
  tmr_cfg_t   cfg_v [NU];

  tmr_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .tick(tick)
  );

  tmr_edge #(.N(NU)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cnt_in), .fall(fall)
  );

  for (genvar i = 0; i < NU; i++) begin : g_unit
    logic allow;
    assign cfg_v[i] = tmr_cfg_t'(cfg_q[4*i +: 4]);
    assign allow    = run[i] & (~cfg_v[i].gate_en | gate_in[i]);
    assign inc[i]   = allow & (cfg_v[i].ext_src ? fall[i] : tick);

    tmr_core #(.SPLIT_OK(i == 0)) u_core (
      .clk(clk), .rst_n(rst_n),
      .lay(cfg_v[i].lay),
      .inc(inc[i]),
      .inc_hi((i == 0) ? (run[1] & tick) : 1'b0),
      .wr_lo(wr_en && addr == 3'(2*i)),
      .wr_hi(wr_en && addr == 3'(2*i + 1)),
      .wdata(wdata),
      .lo(lo_v[i]), .hi(hi_v[i]),
      .ovf(ovf[i]), .ovf_hi(ovf_hi[i])
    );
  end

  assign set_v[0] = ovf[0];
  assign set_v[1] = (cfg_v[0].lay == LAY_SPLIT) ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      ovf_flag  <= '0;
      ovf_pulse <= '0;
    end else begin
      if (wr_en && addr == A_CFG) cfg_q <= wdata;
      ovf_flag  <= (ovf_flag & ~flag_clr) | set_v;
      ovf_pulse <= set_v;
    end
  end

  always_comb begin
    case (addr)
      A_LO0:   rdata = lo_v[0];
      A_HI0:   rdata = hi_v[0];
      A_LO1:   rdata = lo_v[1];
      A_HI1:   rdata = hi_v[1];
      A_CFG:   rdata = cfg_q;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [1:0] run,
  input logic [1:0] flag_clr,
  input logic [1:0] ovf_flag,
  input logic [1:0] ovf_pulse,
  input logic [7:0] lo0
);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |=> !ovf_pulse[0]);
  p_pulse_single1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[1] |=> !ovf_pulse[1]);
  p_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |-> ovf_flag[0]);
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag[0] && !flag_clr[0] |=> ovf_flag[0]);
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr[1] |=> !ovf_flag[1] || ovf_pulse[1]);
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd0 |=> lo0 == $past(wdata));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && run[0] == 1'b0 |=> $stable(lo0));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run(run), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
  .ovf_pulse(ovf_pulse), .lo0(lo_v[0])
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fast_sel = 1'b0;
  logic [1:0] run = '0, cnt_in = '0, gate_in = '0, flag_clr = '0;
  logic [1:0] ovf_flag, ovf_pulse;

  int nchk = 0, nerr = 0, pcnt1 = 0;

  always #2.5 clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .fast_sel(fast_sel), .run(run), .cnt_in(cnt_in),
    .gate_in(gate_in), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
    .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (ovf_pulse[1]) pcnt1++;

  function automatic int ticks_in(int cycles, int div);
    return cycles / div;
  endfunction

  function automatic logic [15:0] nxt13(logic [7:0] hi, logic [7:0] lo);
    logic [12:0] v;
    v = {hi, lo[4:0]} + 13'd1;
    return {v[12:5], lo[7:5], v[4:0]};
  endfunction

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(int u, output logic [15:0] v);
    logic [7:0] l, h;
    rd(3'(2*u), l); rd(3'(2*u+1), h);
    v = {h, l};
  endtask

  task automatic fall_once(int u);
    @(negedge clk); cnt_in[u] = 1'b1;
    @(negedge clk);
    @(negedge clk); cnt_in[u] = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic rand_edges(int u, int cycles, output int falls);
    logic prev, b;
    prev = cnt_in[u];
    falls = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      b = 1'($urandom % 2);
      if (prev && !b) falls++;
      prev = b;
      cnt_in[u] = b;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v;
    int f;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 flags", ovf_flag, 0);
    chk("R1 pulses", ovf_pulse, 0);

    // R2 random write/readback with units stopped
    for (int k = 0; k < 20; k++) begin
      logic [2:0] a;
      logic [7:0] x;
      a = 3'($urandom % 5);
      x = 8'($urandom);
      wr(a, x); rd(a, d); chk("R2 readback", d, x);
    end
    for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);

    // R3 tick mode slow and fast, unit 0, 16-bit layout
    wr(3'd4, 8'h01);
    @(negedge clk); run[0] = 1'b1;
    repeat (120) @(negedge clk);
    run[0] = 1'b0;
    rd16(0, v); chk("R3 slow", v, ticks_in(120, 12));
    fast_sel = 1'b1;
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    @(negedge clk); run[0] = 1'b1;
    repeat (120) @(negedge clk);
    run[0] = 1'b0;
    rd16(0, v); chk("R3 fast", v, ticks_in(120, 4));
    fast_sel = 1'b0;

    // R4 stopped unit holds
    repeat (100) @(negedge clk);
    rd16(0, v); chk("R4 hold", v, 30);

    // R5 random external edges, unit 0 16-bit
    wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    @(negedge clk); run[0] = 1'b1;
    rand_edges(0, 200, f);
    rd16(0, v); chk("R5 falls", v, f);

    // R6 gating
    wr(3'd4, 8'h0D); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate_in[0] = 1'b0;
    rand_edges(0, 100, f);
    rd16(0, v); chk("R6 gate closed", v, 0);
    gate_in[0] = 1'b1;
    rand_edges(0, 100, f);
    rd16(0, v); chk("R6 gate open", v, f);
    wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate_in[0] = 1'b0;
    rand_edges(0, 100, f);
    rd16(0, v); chk("R6 gate ignored", v, f);
    run[0] = 1'b0; cnt_in[0] = 1'b0;

    // R7 16-bit overflow on unit 1
    wr(3'd4, 8'h50); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    clr_flags(); pcnt1 = 0;
    run[1] = 1'b1;
    fall_once(1);
    rd16(1, v); chk("R7 pre", v, 16'hFFFF);
    chk("R7 no flag yet", ovf_flag[1], 0);
    fall_once(1);
    rd16(1, v); chk("R7 wrap", v, 16'h0000);
    chk("R7 flag", ovf_flag[1], 1);
    chk("R7 one pulse", pcnt1, 1);

    // R11 flag sticky then cleared
    repeat (30) @(negedge clk);
    chk("R11 sticky", ovf_flag[1], 1);
    clr_flags();
    chk("R11 cleared", ovf_flag[1], 0);
    run[1] = 1'b0; cnt_in[1] = 1'b0;

    // R8 13-bit layout on unit 0
    wr(3'd4, 8'h04); wr(3'd0, 8'hFF); wr(3'd1, 8'h05);
    run[0] = 1'b1;
    fall_once(0);
    rd16(0, v); chk("R8 carry", v, nxt13(8'h05, 8'hFF));
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    clr_flags();
    fall_once(0);
    rd16(0, v); chk("R8 wrap", v, 16'h00E0);
    chk("R8 flag", ovf_flag[0], 1);

    // R9 reload layout
    wr(3'd4, 8'h06); wr(3'd1, 8'h80); wr(3'd0, 8'hFE);
    clr_flags();
    fall_once(0);
    rd16(0, v); chk("R9 step", v, 16'h80FF);
    chk("R9 no flag", ovf_flag[0], 0);
    fall_once(0);
    rd16(0, v); chk("R9 reload", v, 16'h8080);
    chk("R9 flag", ovf_flag[0], 1);
    run[0] = 1'b0; cnt_in[0] = 1'b0;

    // R10 split layout on unit 0, unit 1 also split (holds)
    wr(3'd4, 8'h37); wr(3'd0, 8'h00); wr(3'd1, 8'hF0);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22);
    clr_flags();
    @(negedge clk); run[1] = 1'b1;
    repeat (192) @(negedge clk);
    run[1] = 1'b0;
    rd(3'd1, d); chk("R10 hi wrap", d, 8'h00);
    chk("R10 flag1", ovf_flag[1], 1);
    rd16(1, v); chk("R10 unit1 hold", v, 16'h2211);
    rd(3'd0, d); chk("R10 lo idle", d, 8'h00);
    run[0] = 1'b1;
    fall_once(0);
    rd(3'd0, d); chk("R10 lo counts", d, 8'h01);
    run[0] = 1'b0; cnt_in[0] = 1'b0;

    // R12 write beats same-cycle increment
    wr(3'd4, 8'h05); wr(3'd0, 8'h10); wr(3'd1, 8'h00);
    @(negedge clk); cnt_in[0] = 1'b1; run[0] = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in[0] = 1'b0;
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 8'h40;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rd16(0, v); chk("R12 write wins", v, 16'h0040);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule